// File: doc/BRIEF.md
# Accumulator Readout Rounding Formatter

This block turns a 48-bit multiply-accumulate accumulator value into the 32-bit word that a store-accumulator operation writes to a general register. A one-cycle request strobe captures the accumulator and three mode controls. One clock later the block presents the formatted word with a one-cycle valid pulse. The word stays on the output until the next request.

The accumulator is taken as an 8-bit extension field in bits [47:40] above a 40-bit fraction in bits [39:0]. In integer mode the low word passes through unchanged. In fractional mode the block can do three things: drop the 8 least significant bits to give a 32-bit fraction, round those 8 bits into a 32-bit fraction, or round the low 24 bits into a 16-bit fraction. The 16-bit fraction is returned in the low half-word with the high half-word zero-filled. The block only reads the accumulator. It does not saturate or write back anything.

Top module: `acc_readout_fmt`

## Requirements
- R1: During and after synchronous reset, before any request, `rd_valid` is 0 and `rd_data` is 0x0000_0000.
- R2: `rd_valid` is high in exactly the cycle after a cycle with `rd_req` high, and low otherwise.
- R3: With `frac_mode`=0, `rd_data` equals `acc_in[31:0]` of the request cycle, whatever `half_sel` and `round_en` are.
- R4: With `frac_mode`=1, `half_sel`=0 and `round_en`=0, `rd_data` equals `acc_in[39:8]`. The 8 low bits are dropped.
- R5: With `frac_mode`=1, `half_sel`=0 and `round_en`=1, `rd_data` is `acc_in[39:8]` rounded by `acc_in[7:0]`. A field above 0x80 adds one, and a field below 0x80 adds nothing.
- R6: When the rounding field equals exactly half of one kept lsb (0x80 for 32-bit results, 0x80_0000 for 16-bit results), the result is the even one of the two neighbours, so its lsb is 0.
- R7: With `frac_mode`=1 and `half_sel`=1, `rd_data[15:0]` is `acc_in[39:24]` rounded to nearest by `acc_in[23:0]`. `round_en` has no effect.
- R8: In the 16-bit fractional format, `rd_data[31:16]` is zero.
- R9: A round-up applied to the largest positive kept value clamps instead of wrapping. The result is 0x7FFF_FFFF for the 32-bit format and 0x0000_7FFF for the 16-bit format.
- R10: Without a request, `rd_data` holds its last value. In fractional modes the extension bits `acc_in[47:40]` do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Store-accumulator request strobe |
| acc_in | input | 48 | Accumulator value to format |
| frac_mode | input | 1 | 1: fractional operands, 0: integer |
| half_sel | input | 1 | In fractional mode, 1 selects the rounded 16-bit result |
| round_en | input | 1 | In 32-bit fractional mode, 1 rounds and 0 truncates |
| rd_data | output | 32 | Formatted result word |
| rd_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The assertions check on every cycle the cycle relationship between request and valid, the integer pass-through, the truncated slice, the zero upper half-word, and that the result holds between requests. They also check that a 32-bit rounded result is always the kept slice or one above it. Which neighbour the rounding actually picks cannot be checked cycle by cycle. That covers the tie-to-even choice, the clamp at the positive limit, negative wrap-through-zero and ignoring the extension byte. The bench shows these with directed accumulator patterns whose expected words are worked out beforehand.

// File: rtl/acc_fmt_pkg.sv
package acc_fmt_pkg;

    // Output formats chosen by the three control bits
    typedef enum logic [1:0] {
        FMT_INT     = 2'd0,
        FMT_TRUNC32 = 2'd1,
        FMT_RND32   = 2'd2,
        FMT_RND16   = 2'd3
    } fmt_mode_e;

    typedef struct packed {
        logic frac;
        logic half;
        logic rnd;
    } fmt_ctrl_t;

    // Map control bits to a format; half-word selection overrides round/truncate
    function automatic fmt_mode_e decode_mode(input fmt_ctrl_t c);
        fmt_mode_e m;
        if (!c.frac)     m = FMT_INT;
        else if (c.half) m = FMT_RND16;
        else if (c.rnd)  m = FMT_RND32;
        else             m = FMT_TRUNC32;
        return m;
    endfunction

endpackage

// File: rtl/acc_fmt_mode_dec.sv
module acc_fmt_mode_dec
    import acc_fmt_pkg::*;
(
    input  logic      frac_mode,
    input  logic      half_sel,
    input  logic      round_en,
    output fmt_mode_e mode
);
    fmt_ctrl_t ctrl;

    always_comb begin
        ctrl.frac = frac_mode;
        ctrl.half = half_sel;
        ctrl.rnd  = round_en;
        mode      = decode_mode(ctrl);
    end
endmodule

// File: rtl/acc_fmt_round.sv
// Round-to-nearest-even of a signed fixed-point slice, clamping at the positive limit
module acc_fmt_round #(
    parameter int IN_W   = 40,
    parameter int DROP_W = 8
) (
    input  logic [IN_W-1:0]        val,
    output logic [IN_W-DROP_W-1:0] rounded,
    output logic [IN_W-DROP_W-1:0] truncated
);
    localparam int KEEP_W = IN_W - DROP_W;
    localparam logic [DROP_W-1:0] HALF_LSB = {1'b1, {(DROP_W-1){1'b0}}};
    localparam logic [KEEP_W-1:0] MAX_POS  = {1'b0, {(KEEP_W-1){1'b1}}};

    logic [KEEP_W-1:0] kept;
    logic [DROP_W-1:0] field;
    logic              above_half;
    logic              at_half;
    logic              bump;

    always_comb begin
        kept       = val[IN_W-1:DROP_W];
        field      = val[DROP_W-1:0];
        above_half = field > HALF_LSB;
        at_half    = field == HALF_LSB;
        // tie: bump only an odd value, so the kept lsb ends at 0
        bump       = above_half | (at_half & kept[0]);
        truncated  = kept;
        if (bump && kept == MAX_POS)
            rounded = MAX_POS;
        else
            rounded = kept + KEEP_W'(bump);
    end
endmodule

// File: rtl/acc_fmt_out_reg.sv
module acc_fmt_out_reg #(
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OUT_W-1:0] next_word,
    output logic [OUT_W-1:0] word_q,
    output logic             valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
            if (load)
                word_q <= next_word;
        end
    end
endmodule

// File: rtl/acc_readout_fmt.sv
module acc_readout_fmt
    import acc_fmt_pkg::*;
#(
    parameter int ACC_W  = 48,
    parameter int EXT_W  = 8,
    parameter int OUT_W  = 32,
    parameter int HALF_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_req,
    input  logic [ACC_W-1:0] acc_in,
    input  logic             frac_mode,
    input  logic             half_sel,
    input  logic             round_en,
    output logic [OUT_W-1:0] rd_data,
    output logic             rd_valid
);
    localparam int FRAC_W   = ACC_W - EXT_W;
    localparam int DROP_W32 = FRAC_W - OUT_W;
    localparam int DROP_W16 = FRAC_W - HALF_W;

    fmt_mode_e         mode;
    logic [FRAC_W-1:0] frac_val;
    logic [OUT_W-1:0]  rnd32;
    logic [OUT_W-1:0]  trn32;
    logic [HALF_W-1:0] rnd16;
    logic [HALF_W-1:0] trn16_unused;
    logic [OUT_W-1:0]  next_word;

    assign frac_val = acc_in[FRAC_W-1:0];

    acc_fmt_mode_dec mode_dec_i (
        .frac_mode (frac_mode),
        .half_sel  (half_sel),
        .round_en  (round_en),
        .mode      (mode)
    );

    acc_fmt_round #(.IN_W(FRAC_W), .DROP_W(DROP_W32)) round32_i (
        .val       (frac_val),
        .rounded   (rnd32),
        .truncated (trn32)
    );

    acc_fmt_round #(.IN_W(FRAC_W), .DROP_W(DROP_W16)) round16_i (
        .val       (frac_val),
        .rounded   (rnd16),
        .truncated (trn16_unused)
    );

    always_comb begin
        unique case (mode)
            FMT_INT:     next_word = acc_in[OUT_W-1:0];
            FMT_TRUNC32: next_word = trn32;
            FMT_RND32:   next_word = rnd32;
            FMT_RND16:   next_word = {{(OUT_W-HALF_W){1'b0}}, rnd16};
            default:     next_word = '0;
        endcase
    end

    acc_fmt_out_reg #(.OUT_W(OUT_W)) out_reg_i (
        .clk       (clk),
        .rst       (rst),
        .load      (rd_req),
        .next_word (next_word),
        .word_q    (rd_data),
        .valid_q   (rd_valid)
    );
endmodule

// File: rtl/acc_readout_fmt_chk.sv
module acc_readout_fmt_chk #(
    parameter int ACC_W  = 48,
    parameter int EXT_W  = 8,
    parameter int OUT_W  = 32,
    parameter int HALF_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_req,
    input logic [ACC_W-1:0] acc_in,
    input logic             frac_mode,
    input logic             half_sel,
    input logic             round_en,
    input logic [OUT_W-1:0] rd_data,
    input logic             rd_valid
);
    localparam int FRAC_W   = ACC_W - EXT_W;
    localparam int DROP_W32 = FRAC_W - OUT_W;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!rd_valid && rd_data == '0));

    assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    assert_no_valid_without_req_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    assert_int_passthrough_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !frac_mode) |=> rd_data == $past(acc_in[OUT_W-1:0]));

    assert_trunc_slice_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && frac_mode && !half_sel && !round_en)
            |=> rd_data == $past(acc_in[FRAC_W-1:DROP_W32]));

    assert_round_neighbour_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && frac_mode && !half_sel && round_en)
            |=> (rd_data == $past(acc_in[FRAC_W-1:DROP_W32])
                 || rd_data == $past(acc_in[FRAC_W-1:DROP_W32]) + 1'b1));

    assert_zero_upper_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && frac_mode && half_sel) |=> rd_data[OUT_W-1:HALF_W] == '0);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(rd_data));
endmodule

bind acc_readout_fmt acc_readout_fmt_chk #(
    .ACC_W  (ACC_W),
    .EXT_W  (EXT_W),
    .OUT_W  (OUT_W),
    .HALF_W (HALF_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .acc_in    (acc_in),
    .frac_mode (frac_mode),
    .half_sel  (half_sel),
    .round_en  (round_en),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
);

// File: tb/acc_readout_fmt_tb.sv
`timescale 1ns/1ps
module acc_readout_fmt_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req = 1'b0;
    logic [47:0] acc_in = '0;
    logic        frac_mode = 1'b0;
    logic        half_sel = 1'b0;
    logic        round_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    acc_readout_fmt dut_i (
        .clk(clk), .rst(rst), .rd_req(rd_req), .acc_in(acc_in),
        .frac_mode(frac_mode), .half_sel(half_sel), .round_en(round_en),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Issue one request, check the result word and the valid pulse shape (R2)
    task automatic do_read(input string req, input logic [47:0] a, input logic f,
                           input logic h, input logic r, input logic [31:0] exp);
        @(negedge clk);
        acc_in = a; frac_mode = f; half_sel = h; round_en = r; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(req, rd_data, exp);
        check("R2 valid pulse", {31'd0, rd_valid}, 32'd1);
        @(negedge clk);
        check("R2 valid drop", {31'd0, rd_valid}, 32'd0);
    endtask

    // Independent reference: division-style rounding of the 40-bit fraction
    function automatic logic [31:0] ref_round(input logic [47:0] a, input int drop, input int keep);
        longint unsigned x, q, rem, unit, maxp;
        x    = longint'(a[39:0]);
        unit = 64'd1 << drop;
        q    = x / unit;
        rem  = x % unit;
        maxp = (64'd1 << (keep - 1)) - 1;
        if (2 * rem > unit || (2 * rem == unit && q[0])) begin
            if (q != maxp) q = (q + 1) % (64'd1 << keep);
        end
        return q[31:0];
    endfunction

    task automatic test_reset;
        @(negedge clk);
        check("R1 reset data", rd_data, 32'h0);
        check("R1 reset valid", {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic test_integer;
        do_read("R3 int", 48'hAB12_3456_789A, 1'b0, 1'b0, 1'b0, 32'h3456_789A);
        do_read("R3 int ctrl ignored", 48'hAB12_3456_78FF, 1'b0, 1'b1, 1'b1, 32'h3456_78FF);
    endtask

    task automatic test_truncate;
        do_read("R4 trunc", 48'h0012_3456_78FF, 1'b1, 1'b0, 1'b0, 32'h1234_5678);
        do_read("R10 ext ignored", 48'h5A12_3456_7800, 1'b1, 1'b0, 1'b0, 32'h1234_5678);
    endtask

    task automatic test_round32;
        do_read("R5 round up", 48'h0012_3456_7881, 1'b1, 1'b0, 1'b1, 32'h1234_5679);
        do_read("R5 round down", 48'h0012_3456_787F, 1'b1, 1'b0, 1'b1, 32'h1234_5678);
        do_read("R6 tie even stays", 48'h0012_3456_7880, 1'b1, 1'b0, 1'b1, 32'h1234_5678);
        do_read("R6 tie odd up", 48'h0012_3456_7980, 1'b1, 1'b0, 1'b1, 32'h1234_567A);
        do_read("R5 negative wrap", 48'hFFFF_FFFF_FFC0, 1'b1, 1'b0, 1'b1, 32'h0000_0000);
        do_read("R9 clamp32", 48'h007F_FFFF_FFC0, 1'b1, 1'b0, 1'b1, 32'h7FFF_FFFF);
    endtask

    task automatic test_round16;
        do_read("R6 tie16 even", 48'h0012_3480_0000, 1'b1, 1'b1, 1'b0, 32'h0000_1234);
        do_read("R6 tie16 odd", 48'h0012_3580_0000, 1'b1, 1'b1, 1'b1, 32'h0000_1236);
        do_read("R7 above half", 48'h0012_3480_0001, 1'b1, 1'b1, 1'b0, 32'h0000_1235);
        do_read("R8 negative zero fill", 48'h0080_0012_3456, 1'b1, 1'b1, 1'b1, 32'h0000_8000);
        do_read("R9 clamp16", 48'h007F_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 32'h0000_7FFF);
    endtask

    task automatic test_hold;
        do_read("R10 before hold", 48'h0000_1111_2222, 1'b0, 1'b0, 1'b0, 32'h1111_2222);
        @(negedge clk);
        acc_in = 48'hFFFF_FFFF_FFFF; frac_mode = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 hold data", rd_data, 32'h1111_2222);
        check("R2 no valid", {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic test_sweep;
        logic [47:0] a = 48'h1357_9BDF_2468;
        for (int i = 0; i < 24; i++) begin
            a = {a[46:0], a[47] ^ a[41] ^ a[20] ^ a[0]} ^ (48'h0000_0000_0080 << (i % 3));
            do_read("R5 sweep32", a, 1'b1, 1'b0, 1'b1, ref_round(a, 8, 32));
            do_read("R7 sweep16", a, 1'b1, 1'b1, 1'b1, {16'h0, ref_round(a, 24, 16)[15:0]});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset;
        rst = 1'b0;
        test_reset;
        test_integer;
        test_truncate;
        test_round32;
        test_round16;
        test_hold;
        test_sweep;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule